// File: doc/BRIEF.md
# Dual-Sequence Conversion Sequencer

This block schedules analog-to-digital conversions for two independent conversion sequences, A and B. Each sequence owns a channel mask, a hardware trigger mask with a selectable active edge, and three mode bits: single-step, burst and completion-event granularity. When a sequence is launched, the block walks its selected channels and sends one convert request per channel to an external converter. It then waits for that converter's done pulse and stores the result in a per-channel result slot.

A priority input decides which sequence wins the converter when both have work. The winner is re-chosen at every conversion boundary, so a high-priority sequence started mid-pass takes over after the conversion in flight. The interrupted sequence then continues from the channel it had not yet converted. Status flags record per-channel overruns, per-sequence overruns, per-sequence completion events and a summary overrun flag. Each flag is cleared by writing a one to its bit.

The converter side is a stream. `conv_req_valid` stays high, with `conv_req_chan` unchanged, until `conv_req_ready` is seen high at a clock edge. Only one conversion is outstanding at a time. The converter answers with a single-cycle `conv_done_valid` and cannot be back-pressured. A done pulse that arrives while nothing is outstanding is ignored.

Top module: `conv_seq_ctrl`

## Requirements
- R1: A launched pass converts every channel whose bit is set in the sequence's channel mask exactly once, in ascending channel order starting from the lowest set bit.
- R2: A sequence is launched by a one-cycle `sw_start` pulse, or by an edge on any hardware trigger bit enabled in its trigger mask. Polarity 1 selects rising edges and 0 selects falling edges. Edges on trigger bits outside the mask do nothing.
- R3: While a sequence's enable is low, its software and hardware triggers are ignored and it issues no requests.
- R4: In single-step mode each launch converts only the next channel of the pass. After the highest selected channel, the next launch starts over at the lowest.
- R5: In burst mode a sequence relaunches itself continuously. When burst is cleared, the pass in progress completes and no further conversions follow.
- R6: With event mode 0, a sequence sets its event flag after every conversion. With mode 1, it sets the flag only when a pass completes. A's event is flag bit 28 and B's is bit 29.
- R7: When both sequences want the converter, the high-priority one is served: B when `cfg_b_high`=1, otherwise A. A preempted sequence resumes at its first unconverted channel.
- R8: A result written to a channel whose previous result has not been read sets flag bit 12+channel. It also sets the owning sequence's overrun bit (24 for A, 25 for B) and bit 31. Writing 1 to a bit in `flag_clr` clears only that bit; a set in the same cycle wins.
- R9: A hardware trigger edge produces `conv_req_valid` 4 cycles after the input changes through the two-stage synchronizer. With bypass set, it takes 2 cycles.
- R10: A pending request holds its valid and channel until accepted, and at most one conversion is outstanding.
- R11: After reset, all flags are 0, no request is pending and no result is valid.
- R12: `rd_data`/`rd_valid` show the stored result of channel `rd_chan`; an `rd_en` pulse clears that channel's valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 2 | Per-sequence enable (bit 0 = A, bit 1 = B) |
| cfg_chan_mask | input | 2x12 | Per-sequence channel selection |
| cfg_trig_mask | input | 2x6 | Per-sequence hardware trigger selection |
| cfg_trig_rise | input | 2 | Trigger edge: 1 rising, 0 falling |
| cfg_single | input | 2 | Single-step mode |
| cfg_burst | input | 2 | Burst (continuous) mode |
| cfg_evt_pass | input | 2 | Event granularity: 0 per conversion, 1 per pass |
| cfg_bypass | input | 2 | Skip trigger synchronizer |
| cfg_b_high | input | 1 | 1: B has priority, 0: A has priority |
| sw_start | input | 2 | Software launch pulse per sequence |
| hw_trig | input | 6 | Hardware trigger inputs |
| conv_req_valid | output | 1 | Convert request valid |
| conv_req_ready | input | 1 | Converter accepts request |
| conv_req_chan | output | 4 | Channel to convert |
| conv_done_valid | input | 1 | Conversion finished (one cycle) |
| conv_result | input | 12 | Conversion result |
| rd_en | input | 1 | Read pulse; clears valid of `rd_chan` |
| rd_chan | input | 4 | Result channel to view |
| rd_data | output | 12 | Stored result of `rd_chan` |
| rd_valid | output | 1 | Result of `rd_chan` is unread |
| flag_clr | input | 32 | Write-one-to-clear for flags |
| flags_o | output | 32 | Status flags |

## Verification
A corrupted remaining-channel set shows at the converter port on the next request. The channel would be out of order or skipped, and it is visible one cycle after the previous done. A wrong arbitration or owner record shows as an interleaving of A and B channels that differs from the priority rule. It also sets the wrong sequence's event or overrun flag on the clock after the done pulse. Synchronizer depth errors move the first request by whole cycles, so the bench pins the exact edge at which `conv_req_valid` rises for both trigger paths.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int NSEQ        = 2;
  // flag layout; the channel-overrun field must hold every channel
  localparam int FLG_CH_OVR  = 12;
  localparam int FLG_SEQ_OVR = 24;
  localparam int FLG_SEQ_EVT = 28;
  localparam int FLG_OVR_IRQ = 31;
  localparam int FLG_W       = 32;
endpackage

// File: rtl/conv_trig_sync.sv
module conv_trig_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/conv_seq_unit.sv
module conv_seq_unit #(
  parameter int NCH   = 12,
  parameter int NTRIG = 6,
  parameter int CW    = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [NCH-1:0]   cfg_chan_mask,
  input  logic [NTRIG-1:0] cfg_trig_mask,
  input  logic             cfg_trig_rise,
  input  logic             cfg_single,
  input  logic             cfg_burst,
  input  logic             cfg_evt_pass,
  input  logic             cfg_bypass,
  input  logic [NTRIG-1:0] trig_raw,
  input  logic [NTRIG-1:0] trig_sync,
  input  logic             sw_start,
  input  logic             done_i,
  input  logic [CW-1:0]    done_chan,
  output logic             want_o,
  output logic [CW-1:0]    want_chan_o,
  output logic             evt_o
);
  logic             go_q;
  logic [NCH-1:0]   rem_q, rem_d;
  logic [NTRIG-1:0] lvl, prev_q, edge_hit;
  logic             hw_fire, launch;

  // trigger edge detection on the selected path
  assign lvl      = cfg_bypass ? trig_raw : trig_sync;
  assign edge_hit = cfg_trig_rise ? (lvl & ~prev_q) : (~lvl & prev_q);
  assign hw_fire  = |(edge_hit & cfg_trig_mask);
  // burst acts as a launch that is always present
  assign launch   = cfg_en & ~go_q & (|cfg_chan_mask) & (cfg_burst | hw_fire | sw_start);

  always_comb begin
    rem_d = rem_q;
    if (done_i) rem_d = rem_q & ~(NCH'(1) << done_chan);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      go_q   <= 1'b0;
      rem_q  <= '0;
    end else begin
      prev_q <= lvl;
      if (!cfg_en) begin
        go_q  <= 1'b0;
        rem_q <= '0;
      end else if (launch) begin
        go_q  <= 1'b1;
        rem_q <= (rem_d == '0) ? cfg_chan_mask : rem_d;
      end else begin
        rem_q <= rem_d;
        if (done_i && (cfg_single || rem_d == '0)) go_q <= 1'b0;
      end
    end
  end

  // lowest remaining channel goes first
  always_comb begin
    want_chan_o = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (rem_q[i]) want_chan_o = CW'(i);
  end

  assign want_o = go_q & (|rem_q);
  assign evt_o  = cfg_en & done_i & (~cfg_evt_pass | (rem_d == '0));

  // R3
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !want_o);

  // R4
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_single && cfg_en && done_i && go_q) |=> !want_o);
endmodule

// File: rtl/conv_result_bank.sv
module conv_result_bank #(
  parameter int NCH   = 12,
  parameter int RES_W = 12,
  parameter int CW    = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CW-1:0]    wr_chan,
  input  logic [RES_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [CW-1:0]    rd_chan,
  output logic [RES_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             ovr_hit
);
  logic [RES_W-1:0] data_q [NCH];
  logic [NCH-1:0]   dv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q <= '0;
      for (int ch = 0; ch < NCH; ch++) data_q[ch] <= '0;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (wr && wr_chan == CW'(ch)) begin
          data_q[ch] <= wr_data;
          dv_q[ch]   <= 1'b1;
        end else if (rd_en && rd_chan == CW'(ch)) begin
          dv_q[ch] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_data  = '0;
    rd_valid = 1'b0;
    ovr_hit  = 1'b0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (rd_chan == CW'(ch)) begin
        rd_data  = data_q[ch];
        rd_valid = dv_q[ch];
      end
      if (wr && wr_chan == CW'(ch) && dv_q[ch] && !(rd_en && rd_chan == wr_chan))
        ovr_hit = 1'b1;
    end
  end

  // R12
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(wr && wr_chan == rd_chan)) ##1 $stable(rd_chan) |-> !rd_valid);

  // R12
  wr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr ##1 (rd_chan == $past(wr_chan)) |-> rd_valid);
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int NCH   = 12,
  parameter int NTRIG = 6,
  parameter int RES_W = 12,
  parameter int CW    = $clog2(NCH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSEQ-1:0]            cfg_en,
  input  logic [NSEQ-1:0][NCH-1:0]   cfg_chan_mask,
  input  logic [NSEQ-1:0][NTRIG-1:0] cfg_trig_mask,
  input  logic [NSEQ-1:0]            cfg_trig_rise,
  input  logic [NSEQ-1:0]            cfg_single,
  input  logic [NSEQ-1:0]            cfg_burst,
  input  logic [NSEQ-1:0]            cfg_evt_pass,
  input  logic [NSEQ-1:0]            cfg_bypass,
  input  logic                       cfg_b_high,
  input  logic [NSEQ-1:0]            sw_start,
  input  logic [NTRIG-1:0]           hw_trig,
  output logic                       conv_req_valid,
  input  logic                       conv_req_ready,
  output logic [CW-1:0]              conv_req_chan,
  input  logic                       conv_done_valid,
  input  logic [RES_W-1:0]           conv_result,
  input  logic                       rd_en,
  input  logic [CW-1:0]              rd_chan,
  output logic [RES_W-1:0]           rd_data,
  output logic                       rd_valid,
  input  logic [FLG_W-1:0]           flag_clr,
  output logic [FLG_W-1:0]           flags_o
);
  logic [NTRIG-1:0]          trig_s;
  logic [NSEQ-1:0]           want, done_s, evt;
  logic [NSEQ-1:0][CW-1:0]   want_chan;
  logic                      req_v_q, busy_q, owner_q;
  logic [CW-1:0]             req_chan_q;
  logic                      hi, lo, pick, any_want, ovr_hit;
  logic [FLG_W-1:0]          flags_q, fset;

  conv_trig_sync #(.W(NTRIG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(hw_trig), .q(trig_s)
  );

  for (genvar s = 0; s < NSEQ; s++) begin : g_seq
    assign done_s[s] = busy_q & conv_done_valid & (owner_q == 1'(s));
    conv_seq_unit #(.NCH(NCH), .NTRIG(NTRIG), .CW(CW)) u_unit (
      .clk(clk), .rst_n(rst_n),
      .cfg_en(cfg_en[s]), .cfg_chan_mask(cfg_chan_mask[s]),
      .cfg_trig_mask(cfg_trig_mask[s]), .cfg_trig_rise(cfg_trig_rise[s]),
      .cfg_single(cfg_single[s]), .cfg_burst(cfg_burst[s]),
      .cfg_evt_pass(cfg_evt_pass[s]), .cfg_bypass(cfg_bypass[s]),
      .trig_raw(hw_trig), .trig_sync(trig_s), .sw_start(sw_start[s]),
      .done_i(done_s[s]), .done_chan(req_chan_q),
      .want_o(want[s]), .want_chan_o(want_chan[s]), .evt_o(evt[s])
    );
  end

  // arbitration happens at every conversion boundary
  assign hi       = cfg_b_high;
  assign lo       = ~cfg_b_high;
  assign pick     = want[hi] ? hi : lo;
  assign any_want = |want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_v_q    <= 1'b0;
      busy_q     <= 1'b0;
      owner_q    <= 1'b0;
      req_chan_q <= '0;
    end else if (!req_v_q && !busy_q && any_want) begin
      req_v_q    <= 1'b1;
      req_chan_q <= want_chan[pick];
      owner_q    <= pick;
    end else if (req_v_q && conv_req_ready) begin
      req_v_q <= 1'b0;
      busy_q  <= 1'b1;
    end else if (busy_q && conv_done_valid) begin
      busy_q <= 1'b0;
    end
  end

  assign conv_req_valid = req_v_q;
  assign conv_req_chan  = req_chan_q;

  conv_result_bank #(.NCH(NCH), .RES_W(RES_W), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr(|done_s), .wr_chan(req_chan_q), .wr_data(conv_result),
    .rd_en(rd_en), .rd_chan(rd_chan),
    .rd_data(rd_data), .rd_valid(rd_valid), .ovr_hit(ovr_hit)
  );

  always_comb begin
    fset = '0;
    for (int ch = 0; ch < NCH; ch++)
      if (ovr_hit && req_chan_q == CW'(ch)) fset[FLG_CH_OVR + ch] = 1'b1;
    for (int s = 0; s < NSEQ; s++) begin
      if (ovr_hit && owner_q == 1'(s)) fset[FLG_SEQ_OVR + s] = 1'b1;
      if (evt[s]) fset[FLG_SEQ_EVT + s] = 1'b1;
    end
    fset[FLG_OVR_IRQ] = ovr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | fset;
  end

  assign flags_o = flags_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_valid && !conv_req_ready) |=> (conv_req_valid && $stable(conv_req_chan)));

  // R10
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_valid && conv_req_ready) |=> !conv_req_valid);

  // R7
  prio_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_req_valid && !busy_q && (&want)) |=> (owner_q == $past(cfg_b_high)));

  // R8
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_hit |=> flags_o[FLG_OVR_IRQ]);

  // R6
  evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> flags_o[FLG_SEQ_EVT]);
endmodule

// File: tb/conv_seq_ctrl_tb.sv
`timescale 1ns/1ps
module conv_seq_ctrl_tb;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]        cfg_en = '0;
  logic [1:0][11:0]  cfg_chan_mask = '0;
  logic [1:0][5:0]   cfg_trig_mask = '0;
  logic [1:0]        cfg_trig_rise = '0, cfg_single = '0, cfg_burst = '0;
  logic [1:0]        cfg_evt_pass = '0, cfg_bypass = '0, sw_start = '0;
  logic              cfg_b_high = 1'b0;
  logic [5:0]        hw_trig = '0;
  logic              conv_req_valid, rdy = 1'b1;
  logic [3:0]        conv_req_chan;
  logic              conv_done_valid;
  logic [11:0]       conv_result;
  logic              rd_en = 1'b0;
  logic [3:0]        rd_chan = '0;
  logic [11:0]       rd_data;
  logic              rd_valid;
  logic [31:0]       flag_clr = '0, flags_o;

  always #5 clk = ~clk;

  conv_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_chan_mask(cfg_chan_mask),
    .cfg_trig_mask(cfg_trig_mask), .cfg_trig_rise(cfg_trig_rise),
    .cfg_single(cfg_single), .cfg_burst(cfg_burst), .cfg_evt_pass(cfg_evt_pass),
    .cfg_bypass(cfg_bypass), .cfg_b_high(cfg_b_high), .sw_start(sw_start),
    .hw_trig(hw_trig), .conv_req_valid(conv_req_valid), .conv_req_ready(rdy),
    .conv_req_chan(conv_req_chan), .conv_done_valid(conv_done_valid),
    .conv_result(conv_result), .rd_en(rd_en), .rd_chan(rd_chan),
    .rd_data(rd_data), .rd_valid(rd_valid), .flag_clr(flag_clr), .flags_o(flags_o)
  );

  // converter model: fixed latency, logs every accepted channel
  logic [3:0]  log_ch [0:255];
  int          log_n;
  logic [11:0] exp_res [0:15];
  int          lat_cnt;
  logic [3:0]  pend_ch;
  logic [7:0]  serial;
  logic        ev_prev;
  int          ev_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      log_n <= 0; lat_cnt <= 0; conv_done_valid <= 1'b0; serial <= '0;
      conv_result <= '0; pend_ch <= '0; ev_prev <= 1'b0; ev_cnt <= 0;
    end else begin
      conv_done_valid <= 1'b0;
      if (conv_req_valid && rdy) begin
        log_ch[log_n] <= conv_req_chan;
        log_n   <= log_n + 1;
        pend_ch <= conv_req_chan;
        lat_cnt <= LAT;
      end else if (lat_cnt > 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) begin
          conv_done_valid  <= 1'b1;
          conv_result      <= {pend_ch, serial};
          exp_res[pend_ch] <= {pend_ch, serial};
          serial           <= serial + 8'd1;
        end
      end
      ev_prev <= flags_o[28];
      if (flags_o[28] && !ev_prev) ev_cnt <= ev_cnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done_flag = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sw(input int s);
    sw_start[s] = 1'b1;
    @(negedge clk);
    sw_start[s] = 1'b0;
  endtask

  // returns index of first order mismatch, or -1
  function automatic int order_err(input int base, input logic [11:0] m);
    int idx = 0;
    for (int k = 0; k < 12; k++)
      if (m[k]) begin
        if (int'(log_ch[base + idx]) != k) return idx;
        idx++;
      end
    return -1;
  endfunction

  task automatic trig_lat(input bit byp, input bit rise, input int exp_edges, input string tag);
    cfg_bypass[0] = byp; cfg_trig_rise[0] = rise; cfg_trig_mask[0] = 6'b000100;
    cfg_chan_mask[0] = 12'h004; cfg_en[0] = 1'b1;
    hw_trig[2] = ~rise;
    tick(8);
    hw_trig[2] = rise;
    for (int k = 1; k <= exp_edges; k++) begin
      @(negedge clk);
      if (k == exp_edges - 1) check({tag, " early"}, conv_req_valid, 0);
      if (k == exp_edges)     check({tag, " on time"}, conv_req_valid, 1);
    end
    tick(20);
  endtask

  task automatic prio_case(input bit bhigh, input int e0, e1, e2, e3, e4, e5);
    int base, exp_l[6], bad;
    exp_l = '{e0, e1, e2, e3, e4, e5};
    cfg_b_high = bhigh;
    cfg_chan_mask[0] = 12'hF00; cfg_chan_mask[1] = 12'h003;
    cfg_en = 2'b11;
    base = log_n;
    pulse_sw(0);
    for (int w = 0; w < 50 && log_n == base; w++) @(negedge clk);
    pulse_sw(1);
    tick(100);
    bad = -1;
    for (int k = 5; k >= 0; k--) if (int'(log_ch[base + k]) != exp_l[k]) bad = k;
    check("R7 interleave mismatch index", bad, -1);
    check("R7 total conversions", log_n - base, 6);
    cfg_en[1] = 1'b0;
  endtask

  localparam logic [12:0] VEC [6] = '{
    {1'b0, 12'h001}, {1'b1, 12'h800}, {1'b0, 12'hA5A},
    {1'b1, 12'hFFF}, {1'b0, 12'h101}, {1'b1, 12'h0C0}
  };

  initial begin
    int base, n0, n1;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R11
    check("R11 flags after reset", int'(flags_o), 0);
    check("R11 request after reset", conv_req_valid, 0);
    check("R11 result valid after reset", rd_valid, 0);

    // R1 / R6 vector walk
    flag_clr = 32'h1000_0000;
    foreach (VEC[i]) begin
      int e0;
      cfg_chan_mask[0] = VEC[i][11:0];
      cfg_evt_pass[0]  = VEC[i][12];
      cfg_en[0] = 1'b1;
      base = log_n; e0 = ev_cnt;
      pulse_sw(0);
      tick(130);
      check("R1 conversion count", log_n - base, $countones(VEC[i][11:0]));
      check("R1 ascending order mismatch index", order_err(base, VEC[i][11:0]), -1);
      check("R6 event count", ev_cnt - e0, VEC[i][12] ? 1 : $countones(VEC[i][11:0]));
    end
    flag_clr = '0;

    // R2 / R9 trigger paths
    trig_lat(1'b0, 1'b1, 4, "R2 R9 sync rising");
    trig_lat(1'b0, 1'b0, 4, "R2 sync falling");
    trig_lat(1'b1, 1'b1, 2, "R9 bypass rising");
    cfg_bypass[0] = 1'b0;
    base = log_n;
    hw_trig[4] = 1'b1; tick(3); hw_trig[4] = 1'b0;
    tick(20);
    check("R2 unmasked trigger ignored", log_n - base, 0);

    // R3 disabled sequence
    cfg_en[0] = 1'b0;
    base = log_n;
    pulse_sw(0);
    hw_trig[2] = 1'b0; tick(3); hw_trig[2] = 1'b1;
    tick(20);
    check("R3 disabled ignores triggers", log_n - base, 0);
    cfg_en[0] = 1'b1;
    tick(10);

    // R4 single step
    cfg_single[0] = 1'b1; cfg_chan_mask[0] = 12'h0A1; cfg_trig_mask[0] = '0;
    base = log_n;
    for (int k = 0; k < 4; k++) begin
      int exp_c;
      exp_c = (k == 1) ? 5 : (k == 2) ? 7 : 0;
      pulse_sw(0);
      tick(20);
      check("R4 one conversion per launch", log_n - base, k + 1);
      check("R4 step channel", int'(log_ch[log_n - 1]), exp_c);
    end
    cfg_single[0] = 1'b0;

    // R5 burst
    cfg_chan_mask[0] = 12'h006;
    base = log_n;
    cfg_burst[0] = 1'b1;
    tick(33);
    cfg_burst[0] = 1'b0;
    tick(40);
    n0 = log_n - base;
    check("R5 burst repeated passes", int'(n0 >= 4), 1);
    check("R5 whole passes only", n0 % 2, 0);
    check("R5 last channel of pass", int'(log_ch[log_n - 1]), 2);
    tick(30);
    check("R5 stopped after clear", log_n - base, n0);

    // R7 priority and resumption
    prio_case(1'b1, 8, 0, 1, 9, 10, 11);
    prio_case(1'b0, 8, 9, 10, 11, 0, 1);

    // R8 / R12 overrun and read
    cfg_chan_mask[0] = 12'h008; cfg_evt_pass[0] = 1'b0;
    rd_chan = 4'd3; rd_en = 1'b1; flag_clr = '1;
    tick(1);
    rd_en = 1'b0; flag_clr = '0;
    pulse_sw(0); tick(20);
    check("R12 result valid after write", rd_valid, 1);
    check("R12 result data", int'(rd_data), int'(exp_res[3]));
    check("R8 no overrun on first write", int'(flags_o[15]), 0);
    pulse_sw(0); tick(20);
    check("R8 channel overrun bit", int'(flags_o[15]), 1);
    check("R8 sequence A overrun bit", int'(flags_o[24]), 1);
    check("R8 summary overrun bit", int'(flags_o[31]), 1);
    flag_clr = 32'h0000_8000; tick(1); flag_clr = '0;
    check("R8 cleared bit", int'(flags_o[15]), 0);
    check("R8 other bit kept", int'(flags_o[24]), 1);
    rd_en = 1'b1; tick(1); rd_en = 1'b0;
    check("R12 read clears valid", rd_valid, 0);
    pulse_sw(0); tick(20);
    check("R8 no overrun after read", int'(flags_o[15]), 0);

    // R10 back-pressure
    rdy = 1'b0;
    cfg_chan_mask[0] = 12'h010;
    base = log_n;
    pulse_sw(0); tick(5);
    check("R10 request pending", conv_req_valid, 1);
    check("R10 request channel", int'(conv_req_chan), 4);
    tick(5);
    check("R10 request held", conv_req_valid, 1);
    check("R10 channel held", int'(conv_req_chan), 4);
    rdy = 1'b1; tick(1);
    check("R10 accepted once", log_n - base, 1);
    n1 = log_n;
    tick(20);
    check("R10 no second request", log_n - n1, 0);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule